// File: doc/BRIEF.md
# I2C Master Control Command Sequencer

This block holds the control register of a multi-master I2C controller and decides, from software writes and from status reported by a separate bit-level engine, when that engine must drive a START, a repeated START or a STOP. It stores three things: the master/slave mode bit, a queued start request, and the transfer interrupt flag. Each decision leaves the block as a one-cycle command pulse on a registered output.

Software writes one 4-bit control word. Bit 0 is the interrupt flag, bit 1 is master select, bit 2 is the repeated-start request and bit 3 is the bus-error interrupt enable. A read of the register returns `{enable, 0, master, flag}`. The bit engine reports four things: bus busy, an arbitration-lost pulse, a transfer-complete pulse and a bus-error level. It also reports whether this node has been addressed as a slave.

The block works at the level of control words and status levels, so it has no data stream. All pins are plain control and status signals with no handshake. A write takes effect at the clock edge where `wr_en` is sampled high. Command pulses and state changes appear in the cycle that follows that edge.

Top module: `i2c_cmd_seq`

## Requirements
- R1: `irq` is high exactly when the stored enable (bit 3) is 1 and `bus_err` is 1, and it follows `bus_err` in the same cycle.
- R2: The repeated-start bit (bit 2) always reads back as 0. Writing it as 0 never issues a command, and writing it as 1 outside a master interrupt also issues no command.
- R3: A write with bit 2 = 1 and bit 1 = 1, made while `master` = 1 and the flag is 1, pulses `cmd_rstart` for one cycle. The flag clears and `master` stays 1.
- R4: An `arb_lost` pulse while `master` = 1 clears `master` at the next edge.
- R5: A write with bit 1 = 0, made while `master` = 1 and the flag is 1, pulses `cmd_stop`, clears `master` and clears the flag.
- R6: A write with bit 1 = 1, made while `master` = 0, `bus_busy` = 0 and no start is pending, pulses `cmd_start` and sets `master`.
- R7: A write with bit 1 = 1, made while `master` = 0 and `bus_busy` = 1, sets `pending`. At the first edge that samples `bus_busy` = 0, `cmd_start` pulses, `master` sets and `pending` clears.
- R8: A pending start is dropped with no `cmd_start` when `slv_hit` or `arb_lost` is sampled high, or when bit 1 is written as 0.
- R9: Each command is a one-cycle pulse, and at most one command is issued per cycle. A write with bit 1 = 0 and bit 2 = 1 during a master interrupt gives STOP only.
- R10: A `xfer_done` pulse sets the flag. A write with bit 0 = 0 clears it, a write with bit 0 = 1 leaves it unchanged, and a set wins over a clear made in the same cycle.
- R11: The synchronous active-high `rst` clears the mode bit, the pending start, the flag, the enable and all command outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 4 | Control word {enable, rep-start, master sel, flag} |
| bus_busy | input | 1 | Bus busy from bit engine |
| arb_lost | input | 1 | Arbitration lost pulse |
| xfer_done | input | 1 | Transfer complete pulse |
| bus_err | input | 1 | Bus error level |
| slv_hit | input | 1 | Node addressed as slave |
| cmd_start | output | 1 | Issue START with address byte |
| cmd_rstart | output | 1 | Issue repeated START |
| cmd_stop | output | 1 | Issue STOP |
| master | output | 1 | Master mode bit |
| pending | output | 1 | Queued start waiting for idle bus |
| int_flag | output | 1 | Transfer interrupt flag |
| irq | output | 1 | Bus-error interrupt request |
| ctrl_rd | output | 4 | Control register read value |

## Verification
The hardest state to reach from the ports is a queued start that is then cancelled. It needs a master-select write while a stubbed `bus_busy` is held high. After that, either `slv_hit` is raised in the same cycle that busy falls, or `arb_lost` arrives while busy is still high. The vector table builds this state step by step and then confirms that no START follows once the bus is idle. Directed tests cover three more cases: a write that asks for both STOP and repeated START during a master interrupt, a flag write of 1 that must leave the flag set, and a reset that arrives while the block is in master mode.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int CTRL_W  = 4;
  localparam int BIT_IF  = 0;
  localparam int BIT_MS  = 1;
  localparam int BIT_RS  = 2;
  localparam int BIT_BEN = 3;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_START  = 2'd1,
    CMD_RSTART = 2'd2,
    CMD_STOP   = 2'd3
  } cmd_e;
endpackage

// File: rtl/i2c_seq_ctrlreg.sv
module i2c_seq_ctrlreg (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_ben,
  input  logic wr_flag,
  input  logic set_done,
  input  logic clr_cmd,
  output logic ben_q,
  output logic flag_q
);
  logic clr_wr;
  assign clr_wr = wr_en & ~wr_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      ben_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_en) ben_q <= wr_ben;
      // a transfer-complete event is never lost to a clear in the same cycle
      if (set_done)               flag_q <= 1'b1;
      else if (clr_wr || clr_cmd) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_seq_mode.sv
module i2c_seq_mode (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_ms,
  input  logic wr_rs,
  input  logic flag,
  input  logic bus_busy,
  input  logic arb_lost,
  input  logic slv_hit,
  output logic master_q,
  output logic pend_q,
  output logic do_start,
  output logic do_rs,
  output logic do_stop
);
  logic ms_one, ms_zero, in_mint, start_now, launch, set_pend, cancel;

  always_comb begin
    ms_one    = wr_en & wr_ms;
    ms_zero   = wr_en & ~wr_ms;
    in_mint   = master_q & flag & ~arb_lost;
    do_stop   = ms_zero & in_mint;
    do_rs     = wr_en & wr_rs & wr_ms & in_mint;
    start_now = ms_one & ~master_q & ~bus_busy & ~pend_q;
    launch    = pend_q & ~bus_busy & ~slv_hit & ~arb_lost;
    do_start  = start_now | launch;
    set_pend  = ms_one & ~master_q & bus_busy & ~slv_hit & ~arb_lost;
    cancel    = slv_hit | arb_lost | ms_zero;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      master_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (arb_lost && master_q) master_q <= 1'b0;
      else if (do_stop)         master_q <= 1'b0;
      else if (do_start)        master_q <= 1'b1;

      if (do_start || cancel) pend_q <= 1'b0;
      else if (set_pend)      pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_seq_cmdout.sv
module i2c_seq_cmdout
  import i2c_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_start,
  input  logic req_rs,
  input  logic req_stop,
  output logic cmd_start,
  output logic cmd_rstart,
  output logic cmd_stop
);
  cmd_e sel, cmd_q;

  always_comb begin
    if (req_stop)       sel = CMD_STOP;
    else if (req_rs)    sel = CMD_RSTART;
    else if (req_start) sel = CMD_START;
    else                sel = CMD_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) cmd_q <= CMD_NONE;
    else     cmd_q <= sel;
  end

  assign cmd_start  = (cmd_q == CMD_START);
  assign cmd_rstart = (cmd_q == CMD_RSTART);
  assign cmd_stop   = (cmd_q == CMD_STOP);
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2c_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              bus_busy,
  input  logic              arb_lost,
  input  logic              xfer_done,
  input  logic              bus_err,
  input  logic              slv_hit,
  output logic              cmd_start,
  output logic              cmd_rstart,
  output logic              cmd_stop,
  output logic              master,
  output logic              pending,
  output logic              int_flag,
  output logic              irq,
  output logic [CTRL_W-1:0] ctrl_rd
);
  logic ben_q, req_start, req_rs, req_stop;

  i2c_seq_ctrlreg u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .wr_ben(wr_data[BIT_BEN]), .wr_flag(wr_data[BIT_IF]),
    .set_done(xfer_done), .clr_cmd(req_stop | req_rs),
    .ben_q(ben_q), .flag_q(int_flag)
  );

  i2c_seq_mode u_mode (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .wr_ms(wr_data[BIT_MS]), .wr_rs(wr_data[BIT_RS]),
    .flag(int_flag), .bus_busy(bus_busy), .arb_lost(arb_lost),
    .slv_hit(slv_hit), .master_q(master), .pend_q(pending),
    .do_start(req_start), .do_rs(req_rs), .do_stop(req_stop)
  );

  i2c_seq_cmdout u_cmd (
    .clk(clk), .rst(rst), .req_start(req_start), .req_rs(req_rs),
    .req_stop(req_stop), .cmd_start(cmd_start), .cmd_rstart(cmd_rstart),
    .cmd_stop(cmd_stop)
  );

  assign irq = ben_q & bus_err;

  always_comb begin
    ctrl_rd          = '0;
    ctrl_rd[BIT_BEN] = ben_q;
    ctrl_rd[BIT_MS]  = master;
    ctrl_rd[BIT_IF]  = int_flag;
  end
endmodule

// File: rtl/i2c_cmd_seq_chk.sv
module i2c_cmd_seq_chk
  import i2c_seq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [CTRL_W-1:0] wr_data,
  input logic              bus_busy,
  input logic              arb_lost,
  input logic              xfer_done,
  input logic              bus_err,
  input logic              slv_hit,
  input logic              cmd_start,
  input logic              cmd_rstart,
  input logic              cmd_stop,
  input logic              master,
  input logic              pending,
  input logic              int_flag,
  input logic              irq,
  input logic [CTRL_W-1:0] ctrl_rd
);
  a_r1_irq_needs_err: assert property (@(posedge clk) disable iff (rst)
    irq |-> bus_err);
  a_r9_one_cmd: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_start, cmd_rstart, cmd_stop}));
  a_r9_start_pulse: assert property (@(posedge clk) disable iff (rst)
    cmd_start |=> !cmd_start);
  a_r4_arb_drop: assert property (@(posedge clk) disable iff (rst)
    (master && arb_lost) |=> !master);
  a_r6_start_sets_master: assert property (@(posedge clk) disable iff (rst)
    cmd_start |-> master);
  a_r3_rstart_keeps_master: assert property (@(posedge clk) disable iff (rst)
    cmd_rstart |-> master);
  a_r8_cancel: assert property (@(posedge clk) disable iff (rst)
    (pending && (slv_hit || arb_lost)) |=> (!pending && !cmd_start));
  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (!master && !pending && !int_flag && !cmd_start));
endmodule

bind i2c_cmd_seq i2c_cmd_seq_chk u_chk (.*);

// File: tb/tb_i2c_cmd_seq.sv
module tb_i2c_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 22;
  // {we, wd[3:0], busy arb done berr hit, st rs sp ms pd if irq}
  localparam logic [16:0] VEC [NV] = '{
    17'b1_0010_00000_1001000, // R6 start on idle bus
    17'b0_0000_10000_0001000,
    17'b0_0000_10100_0001010, // R10 done sets flag
    17'b1_0110_10000_0101000, // R3 repeated start clears flag
    17'b0_0000_10100_0001010,
    17'b1_0000_10000_0010000, // R5 stop
    17'b0_0000_00000_0000000,
    17'b1_0010_10000_0000100, // R7 queued start
    17'b0_0000_10000_0000100,
    17'b0_0000_00000_1001000, // R7 launch on idle
    17'b0_0000_11000_0000000, // R4 arbitration lost
    17'b1_0010_10000_0000100,
    17'b0_0000_00001_0000000, // R8 slave hit cancels
    17'b1_0010_10000_0000100,
    17'b0_0000_11000_0000000, // R8 arb lost cancels
    17'b0_0000_00000_0000000, // R8 no late start
    17'b1_1000_00010_0000001, // R1 irq enabled
    17'b0_0000_00000_0000000, // R1
    17'b1_0000_00010_0000000, // R1 enable cleared
    17'b1_0100_00000_0000000, // R2 rep-start outside master: no command
    17'b0_0000_00100_0000010, // R10
    17'b1_0000_00000_0000000  // R10 write 0 clears
  };

  logic clk = 0, rst = 1, wr_en = 0, bus_busy = 0, arb_lost = 0;
  logic xfer_done = 0, bus_err = 0, slv_hit = 0;
  logic [3:0] wr_data = 0;
  logic cmd_start, cmd_rstart, cmd_stop, master, pending, int_flag, irq;
  logic [3:0] ctrl_rd;
  int tests = 0, fails = 0;
  bit finished = 0;

  i2c_cmd_seq dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [3:0] wd, input logic [4:0] st);
    wr_en = we; wr_data = wd;
    {bus_busy, arb_lost, xfer_done, bus_err, slv_hit} = st;
  endtask

  task automatic step(input logic we, input logic [3:0] wd, input logic [4:0] st);
    drive(we, wd, st);
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [7:0] outs();
    return {1'b0, cmd_start, cmd_rstart, cmd_stop, master, pending, int_flag, irq};
  endfunction

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 0;
    chk("R11 reset outputs", outs(), 8'h00);
    chk("R11 reset readback", {4'h0, ctrl_rd}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][16], VEC[i][15:12], VEC[i][11:7]);
      chk($sformatf("table vec %0d", i), outs(), {1'b0, VEC[i][6:0]});
    end

    // R2 readback of rep-start is 0, no command
    step(1'b1, 4'b1100, 5'b00000);
    chk("R2 readback", {4'h0, ctrl_rd}, 8'h08);
    chk("R2 no command", outs(), 8'h00);
    step(1'b1, 4'b0000, 5'b00000);

    // R9 stop wins over rep-start
    step(1'b1, 4'b0010, 5'b00000);
    step(1'b0, 4'b0000, 5'b10100);
    // R10 write flag=1 in master int: nothing happens
    step(1'b1, 4'b0011, 5'b10000);
    chk("R10 flag write 1 keeps", outs(), 8'h0A);
    step(1'b1, 4'b0100, 5'b10000);
    chk("R9 stop only", outs(), 8'h10);
    step(1'b0, 4'b0000, 5'b00000);
    chk("R9 stop single pulse", outs(), 8'h00);

    // R11 reset in master mode
    step(1'b1, 4'b1010, 5'b00000);
    chk("R6 master before reset", {7'h0, master}, 8'h01);
    drive(1'b0, 4'b0000, 5'b10100);
    rst = 1;
    @(posedge clk); @(negedge clk);
    rst = 0;
    chk("R11 mid reset outputs", outs(), 8'h00);
    chk("R11 mid reset readback", {4'h0, ctrl_rd}, 8'h00);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule